// File: doc/BRIEF.md
# Dual-Axis Quadrature Pointer Counter with Byte Read Port

This block follows pointer motion on two axes. Each axis has a pair of two-phase quadrature inputs that are decoded at every edge into a 12-bit up/down count. Three active-low buttons are sampled at the same time. A host reads everything over an 8-bit bus. An active-low chip select opens a read. An axis select picks X (low) or Y (high). A byte select picks the low byte (low) or the high byte (high).

When chip select falls, the chosen byte is frozen into a snapshot register. The live counters keep moving, but the bus shows the snapshot until chip select rises again. An active-low movement flag reports that a counter stepped while the host was not reading. An active-low button flag reports that any button is held. Every input crosses into the clock domain through a synchroniser before it is used. The bus is modelled as a data word plus an output-enable, so there are no tri-state pads.

Top module: `quad_pointer_port`

## Requirements
- R1: `data_oe` is 1 while the synchronised `cs_n` is low and 0 while it is high, and it changes within 4 clocks of a `cs_n` edge.
- R2: The byte on `data_out` is captured once, when `cs_n` falls, and does not change while `cs_n` stays low, even if the counters step.
- R3: `axis_sel`=0 reads the X counter and 1 reads the Y counter. `byte_sel`=0 reads count bits 7..0 and 1 reads the upper byte.
- R4: `clr_x`=1 sets the X counter to 0 and `clr_y`=1 sets the Y counter to 0. Each leaves the other counter unchanged. A clear during a read does not change the snapshot on the bus.
- R5: The upper byte is {bit7 = button flag (0 when any button is down), bit6 = left level, bit5 = right level, bit4 = middle level, bits3..0 = count bits 11..8}. The button levels are active low, so they read 1 when the button is released.
- R6: `move_flag_n` goes to 0 when either counter steps while `cs_n` is high.
- R7: `move_flag_n` is 1 while `cs_n` is low. A falling edge of `cs_n` clears the pending flag. A step during a read does not set the flag after the read ends.
- R8: `btn_flag_n` is 0 when any of `btn_right_n`, `btn_left_n` or `btn_mid_n` is 0, and 1 otherwise.
- R9: The phase pair {A,B} steps through 00,10,11,01 (A leads) for +1 per edge. The reverse order gives -1. A change of both phases in one sample has no effect on the count.
- R10: The counters wrap modulo 4096. One down step from 0 gives 0xFFF.
- R11: The counters keep counting during a read, so a read after it ends shows the steps made during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select; its falling edge takes the snapshot |
| axis_sel | input | 1 | 0 = X counter, 1 = Y counter |
| byte_sel | input | 1 | 0 = low byte, 1 = upper byte |
| clr_x | input | 1 | Active-high clear of the X counter |
| clr_y | input | 1 | Active-high clear of the Y counter |
| x_a | input | 1 | X axis phase A |
| x_b | input | 1 | X axis phase B |
| y_a | input | 1 | Y axis phase A |
| y_b | input | 1 | Y axis phase B |
| btn_right_n | input | 1 | Right button, active low |
| btn_left_n | input | 1 | Left button, active low |
| btn_mid_n | input | 1 | Middle button, active low |
| data_out | output | 8 | Snapshot byte |
| data_oe | output | 1 | Bus drive enable (models high impedance when 0) |
| move_flag_n | output | 1 | Active-low movement flag |
| btn_flag_n | output | 1 | Active-low button flag |

## Verification
The bench builds the block with its default parameters: a 12-bit count, an 8-bit bus and two synchroniser stages. With a 12-bit count, a single down step from zero reaches the wrap point. The upper byte is then exactly four status bits beside four count bits, so its layout is checked field by field. With two synchroniser stages, the latency from a pin to the snapshot is short, so sampling a few clocks after each edge hits a settled value. Many steps fit inside one held read, and a clear can be placed inside one as well.

// File: rtl/qpad_pkg.sv
package qpad_pkg;

    typedef enum logic [1:0] {
        QD_HOLD = 2'd0,
        QD_UP   = 2'd1,
        QD_DOWN = 2'd2
    } qd_dir_e;

    // One decode step from the previous phase pair to the current one.
    // A single phase change is a valid step; zero or two changes hold.
    function automatic qd_dir_e qd_decode(input logic [1:0] prev_ab,
                                          input logic [1:0] cur_ab);
        logic [1:0] diff;
        diff = prev_ab ^ cur_ab;
        if (diff == 2'b01 || diff == 2'b10) begin
            // up when the new A differs from the old B
            return (cur_ab[1] ^ prev_ab[0]) ? QD_UP : QD_DOWN;
        end
        return QD_HOLD;
    endfunction

endpackage

// File: rtl/qpad_sync.sv
module qpad_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/qpad_axis.sv
module qpad_axis
    import qpad_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             stepped
);

    typedef struct packed {
        logic [1:0]       ab;
        logic [CNT_W-1:0] cnt;
    } axis_st_t;

    axis_st_t st_d, st_q;
    qd_dir_e  dir;

    always_comb begin
        st_d    = st_q;
        st_d.ab = {ph_a, ph_b};
        dir     = qd_decode(st_q.ab, {ph_a, ph_b});
        unique case (dir)
            QD_UP:   st_d.cnt = st_q.cnt + 1'b1;
            QD_DOWN: st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) st_d.cnt = '0;
        stepped = (dir != QD_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R4: a clear leaves the counter at zero on the next clock
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9: without a clear the count moves by at most one per clock
    assert_unit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                  count == $past(count) - 1'b1));

endmodule

// File: rtl/qpad_host.sv
module qpad_host #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              ax_s,
    input  logic              by_s,
    input  logic [CNT_W-1:0]  cnt_x,
    input  logic [CNT_W-1:0]  cnt_y,
    input  logic [3:0]        status,
    input  logic              any_step,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              move_flag_n
);

    localparam int HI_W = DATA_W - 4;

    typedef struct packed {
        logic              cs_prev;
        logic              oe;
        logic              chg;
        logic [DATA_W-1:0] snap;
    } host_st_t;

    host_st_t          st_d, st_q;
    logic [CNT_W-1:0]  live;
    logic [DATA_W-1:0] sel_byte;
    logic              cs_fall;

    always_comb begin
        live     = ax_s ? cnt_y : cnt_x;
        sel_byte = by_s ? {status, HI_W'(live >> DATA_W)} : live[DATA_W-1:0];
        cs_fall  = st_q.cs_prev && !cs_s;

        st_d         = st_q;
        st_d.cs_prev = cs_s;
        st_d.oe      = !cs_s;
        if (cs_fall)             st_d.snap = sel_byte;
        if (cs_fall)             st_d.chg  = 1'b0;
        else if (cs_s && any_step) st_d.chg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out    = st_q.snap;
    assign data_oe     = st_q.oe;
    assign move_flag_n = !(st_q.chg && st_q.cs_prev);

    // R1: the bus enable follows chip select one clock later
    assert_oe_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_s) |=> data_oe);
    assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> !data_oe);

    // R2: the snapshot is stable while the bus stays enabled
    assert_hold_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    // R7: a pending change cannot build up during a read
    assert_no_flag_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !st_q.cs_prev) |=> !st_q.chg);

endmodule

// File: rtl/quad_pointer_port.sv
module quad_pointer_port #(
    parameter int CNT_W       = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              axis_sel,
    input  logic              byte_sel,
    input  logic              clr_x,
    input  logic              clr_y,
    input  logic              x_a,
    input  logic              x_b,
    input  logic              y_a,
    input  logic              y_b,
    input  logic              btn_right_n,
    input  logic              btn_left_n,
    input  logic              btn_mid_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              move_flag_n,
    output logic              btn_flag_n
);

    localparam int                 N_IN   = 12;
    localparam logic [N_IN-1:0]    IN_RST = 12'b1000_0000_0111;

    logic [N_IN-1:0]  raw_in, syn;
    logic [CNT_W-1:0] cnt_x, cnt_y;
    logic             step_x, step_y;
    logic             cs_s, ax_s, by_s, clrx_s, clry_s;
    logic             xa_s, xb_s, ya_s, yb_s, r_s, l_s, m_s;
    logic             sf;

    assign raw_in = {cs_n, axis_sel, byte_sel, clr_x, clr_y,
                     x_a, x_b, y_a, y_b, btn_right_n, btn_left_n, btn_mid_n};

    qpad_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(syn)
    );

    assign {cs_s, ax_s, by_s, clrx_s, clry_s,
            xa_s, xb_s, ya_s, yb_s, r_s, l_s, m_s} = syn;

    qpad_axis #(.CNT_W(CNT_W)) u_axis_x (
        .clk(clk), .rst_n(rst_n), .ph_a(xa_s), .ph_b(xb_s), .clr(clrx_s),
        .count(cnt_x), .stepped(step_x)
    );

    qpad_axis #(.CNT_W(CNT_W)) u_axis_y (
        .clk(clk), .rst_n(rst_n), .ph_a(ya_s), .ph_b(yb_s), .clr(clry_s),
        .count(cnt_y), .stepped(step_y)
    );

    assign sf = r_s & l_s & m_s;

    qpad_host #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ax_s(ax_s), .by_s(by_s),
        .cnt_x(cnt_x), .cnt_y(cnt_y), .status({sf, l_s, r_s, m_s}),
        .any_step(step_x | step_y),
        .data_out(data_out), .data_oe(data_oe), .move_flag_n(move_flag_n)
    );

    assign btn_flag_n = sf;

    // R8: the button flag is low only when some synchronised button is low
    assert_btn_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_flag_n |-> (!r_s || !l_s || !m_s));

endmodule

// File: tb/quad_pointer_port_bench.sv
`timescale 1ns/1ps
module quad_pointer_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, axis_sel = 1'b0, byte_sel = 1'b0;
    logic       clr_x = 1'b0, clr_y = 1'b0;
    logic       x_a = 1'b0, x_b = 1'b0, y_a = 1'b0, y_b = 1'b0;
    logic       btn_right_n = 1'b1, btn_left_n = 1'b1, btn_mid_n = 1'b1;
    logic [7:0] data_out;
    logic       data_oe, move_flag_n, btn_flag_n;

    int n_run = 0;
    int n_fail = 0;
    int mx = 0;
    int my = 0;
    int px = 0;
    int py = 0;

    always #2 clk = ~clk;

    quad_pointer_port u_quad_pointer_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .axis_sel(axis_sel),
        .byte_sel(byte_sel), .clr_x(clr_x), .clr_y(clr_y),
        .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b),
        .btn_right_n(btn_right_n), .btn_left_n(btn_left_n), .btn_mid_n(btn_mid_n),
        .data_out(data_out), .data_oe(data_oe),
        .move_flag_n(move_flag_n), .btn_flag_n(btn_flag_n)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] phase_ab(input int idx);
        case (idx & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic move(input bit y_axis, input int dir, input int n);
        for (int i = 0; i < n; i++) begin
            if (y_axis) begin
                py = py + dir; {y_a, y_b} = phase_ab(py); my = (my + dir) & 12'hFFF;
            end else begin
                px = px + dir; {x_a, x_b} = phase_ab(px); mx = (mx + dir) & 12'hFFF;
            end
            wait_clk(4);
        end
    endtask

    function automatic logic [7:0] upper(input int cnt);
        logic sf;
        sf = btn_right_n & btn_left_n & btn_mid_n;
        return {sf, btn_left_n, btn_right_n, btn_mid_n, 4'(cnt >> 8)};
    endfunction

    task automatic open_read(input bit ax, input bit by);
        axis_sel = ax; byte_sel = by;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(5);
    endtask

    task automatic close_read();
        cs_n = 1'b1;
        wait_clk(5);
    endtask

    task automatic read_check(input string tag, input bit ax, input bit by, input logic [7:0] exp);
        open_read(ax, by);
        check(tag, {8'h0, data_out}, {8'h0, exp});
        close_read();
    endtask

    task automatic t_reset();
        check("R1 reset oe", {15'h0, data_oe}, 16'h0);
        check("R6 reset flag", {15'h0, move_flag_n}, 16'h1);
        check("R8 reset button flag", {15'h0, btn_flag_n}, 16'h1);
        read_check("R3 reset X low", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_bus_enable();
        open_read(1'b0, 1'b0);
        check("R1 oe during read", {15'h0, data_oe}, 16'h1);
        close_read();
        check("R1 oe after read", {15'h0, data_oe}, 16'h0);
    endtask

    task automatic t_direction();
        move(1'b0, 1, 5);
        move(1'b1, -1, 3);
        read_check("R9 X up count", 1'b0, 1'b0, 8'(mx));
        read_check("R9 Y down count", 1'b1, 1'b0, 8'(my));
        read_check("R10 Y wrapped upper", 1'b1, 1'b1, upper(my));
        read_check("R5 X upper layout", 1'b0, 1'b1, upper(mx));
    endtask

    task automatic t_double_change();
        // X sits at an odd phase index; jump both phases at once
        px = px + 2;
        {x_a, x_b} = phase_ab(px);
        wait_clk(4);
        read_check("R9 double change ignored", 1'b0, 1'b0, 8'(mx));
        move(1'b0, 1, 1);
        read_check("R9 step after double change", 1'b0, 1'b0, 8'(mx));
    endtask

    task automatic t_wrap_up();
        move(1'b1, 1, 3);
        read_check("R10 Y back to zero", 1'b1, 1'b0, 8'h00);
        move(1'b1, 1, 300);
        read_check("R10 Y low after 300", 1'b1, 1'b0, 8'(my));
        read_check("R3 Y upper after 300", 1'b1, 1'b1, upper(my));
    endtask

    task automatic t_hold_read();
        logic [7:0] snap;
        open_read(1'b0, 1'b0);
        snap = 8'(mx);
        check("R2 snapshot at open", {8'h0, data_out}, {8'h0, snap});
        move(1'b0, 1, 3);
        check("R2 held during motion", {8'h0, data_out}, {8'h0, snap});
        close_read();
        read_check("R11 counted during read", 1'b0, 1'b0, 8'(mx));
    endtask

    task automatic t_flag();
        open_read(1'b0, 1'b0);
        check("R7 flag high in read", {15'h0, move_flag_n}, 16'h1);
        move(1'b0, -1, 2);
        check("R7 flag high during read motion", {15'h0, move_flag_n}, 16'h1);
        close_read();
        check("R7 no flag from read motion", {15'h0, move_flag_n}, 16'h1);
        move(1'b1, 1, 1);
        check("R6 flag set by Y step", {15'h0, move_flag_n}, 16'h0);
        open_read(1'b0, 1'b0);
        check("R7 flag cleared on open", {15'h0, move_flag_n}, 16'h1);
        close_read();
        check("R7 stays cleared after read", {15'h0, move_flag_n}, 16'h1);
        move(1'b0, 1, 1);
        check("R6 flag set again after read", {15'h0, move_flag_n}, 16'h0);
    endtask

    task automatic t_clear_in_read();
        logic [7:0] snap;
        open_read(1'b0, 1'b0);
        snap = 8'(mx);
        clr_x = 1'b1;
        wait_clk(4);
        clr_x = 1'b0;
        wait_clk(4);
        mx = 0;
        check("R4 snapshot kept over clear", {8'h0, data_out}, {8'h0, snap});
        close_read();
        read_check("R4 X cleared", 1'b0, 1'b0, 8'h00);
        read_check("R4 Y untouched by X clear", 1'b1, 1'b0, 8'(my));
        clr_y = 1'b1;
        wait_clk(4);
        clr_y = 1'b0;
        wait_clk(4);
        my = 0;
        read_check("R4 Y cleared", 1'b1, 1'b0, 8'h00);
        read_check("R4 Y upper cleared", 1'b1, 1'b1, upper(0));
    endtask

    task automatic t_buttons();
        btn_left_n = 1'b0;
        wait_clk(4);
        check("R8 left pressed", {15'h0, btn_flag_n}, 16'h0);
        read_check("R5 upper with left", 1'b0, 1'b1, upper(mx));
        btn_left_n = 1'b1; btn_mid_n = 1'b0;
        wait_clk(4);
        check("R8 mid pressed", {15'h0, btn_flag_n}, 16'h0);
        read_check("R5 upper with mid", 1'b1, 1'b1, upper(my));
        btn_mid_n = 1'b1; btn_right_n = 1'b0;
        wait_clk(4);
        read_check("R5 upper with right", 1'b0, 1'b1, upper(mx));
        btn_right_n = 1'b1;
        wait_clk(4);
        check("R8 all released", {15'h0, btn_flag_n}, 16'h1);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_bus_enable();
        t_direction();
        t_double_change();
        t_wrap_up();
        t_hold_read();
        t_flag();
        t_clear_in_read();
        t_buttons();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule